// File: doc/BRIEF.md
# Scatter-Gather Descriptor List Walker

This block is the front end of a DMA path. Given a base address in memory, it walks a chain of 8-byte descriptors, one after another. For each descriptor it first reads the length word and then the address word over a 32-bit read-request/response port, with one read outstanding at a time. It then presents one segment (address, byte length, final flag) on a valid/ready output to a downstream data mover.

The chain ends at the descriptor whose length word carries the final flag. If the chain reaches the entry cap first, the walk stops and raises an error. A read error from memory also aborts the walk with an error. In direct mode the block reads no descriptors. It emits one final segment built from the base address and a separate length input. A one-cycle done pulse closes every walk and reports how many segments were accepted.

Top module: `sg_walker`

## Requirements
- R1: After reset the walker is idle: `busy`, `mem_req_valid`, `seg_valid`, `done` and `err` are all low.
- R2: Descriptor i sits at base + 8*i. For each descriptor the length word (offset 0) is requested before the address word (offset 4). Only one read is outstanding at a time, and no read is requested while a segment is offered.
- R3: A segment's length is bits [27:0] of the length word, its final flag is bit 31 of the length word, and its address is the address word with bit 31 cleared. Bits [30:28] of the length word have no effect.
- R4: A segment is offered only after both of its words have returned. While `seg_valid` is high and `seg_ready` is low, the segment fields and `seg_valid` stay unchanged.
- R5: Once a segment flagged final is accepted, no further reads or segments follow. `done` is high for exactly the next cycle, with `done_count` equal to the number of segments accepted and `err` low.
- R6: After MAX_ENTRIES (default 256) segments are accepted with no final flag among them, the walk stops, and `done` pulses with `done_count` = MAX_ENTRIES and `err` high. If the final flag sits on entry MAX_ENTRIES, `err` stays low.
- R7: In direct mode (`sg_mode` low at start) the walker issues no reads. It offers exactly one segment with address `base_addr` with bit 31 cleared, length `direct_len` and the final flag set, then pulses `done` with count 1.
- R8: A response with `mem_rsp_err` high ends the walk. No further reads or segments follow, `done` pulses in the next cycle with the count of segments accepted so far, and `err` stays high until the next start.
- R9: `start` has no effect while `busy` is high.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request address and `mem_req_valid` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (sampled while idle) |
| sg_mode | input | 1 | 1: walk descriptors, 0: direct single segment |
| base_addr | input | 32 | Descriptor chain base, or segment address in direct mode |
| direct_len | input | 28 | Segment length in direct mode |
| busy | output | 1 | Walk in progress, including the done cycle |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 32 | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned word |
| mem_rsp_err | input | 1 | Returned word is in error |
| seg_valid | output | 1 | Segment offered |
| seg_ready | input | 1 | Segment accepted |
| seg_addr | output | 32 | Segment start address (bit 31 always clear) |
| seg_len | output | 28 | Segment byte length |
| seg_last | output | 1 | Segment is the last one of the walk |
| done | output | 1 | One-cycle end-of-walk pulse |
| done_count | output | 9 | Segments accepted in the walk, valid with done |
| err | output | 1 | Walk ended by cap or read error |

## Verification
A wrong descriptor index or word select shows up as an unexpected request address on the first read that uses it. A lost or stale field in the segment register shows up as a mismatched address, length or final flag on the segment it belongs to. A broken end-of-list or cap decision is seen at the latest one cycle after the deciding segment is accepted: either extra reads appear, `done` arrives early or late, or `done_count` and `err` are wrong. A mishandled abort is seen as a request issued after the erroring response.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ_LEN,
        ST_WAIT_LEN,
        ST_REQ_PTR,
        ST_WAIT_PTR,
        ST_OFFER,
        ST_FINISH
    } sgw_state_e;

endpackage

// File: rtl/sgw_desc_decode.sv
module sgw_desc_decode #(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 28
) (
    input  logic [WORD_W-1:0] len_word,
    input  logic [WORD_W-1:0] ptr_word,
    output logic [LEN_W-1:0]  seg_len,
    output logic              seg_final,
    output logic [WORD_W-1:0] seg_ptr
);
    logic unused_flag_bits;

    assign seg_len          = len_word[LEN_W-1:0];
    assign seg_final        = len_word[WORD_W-1];
    assign seg_ptr          = {1'b0, ptr_word[WORD_W-2:0]};
    assign unused_flag_bits = ^{len_word[WORD_W-2:LEN_W], ptr_word[WORD_W-1]};
endmodule

// File: rtl/sgw_addr_gen.sv
module sgw_addr_gen #(
    parameter int ADDR_W     = 32,
    parameter int IDX_W      = 9,
    parameter int DESC_BYTES = 8,
    parameter int WORD_BYTES = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    input  logic              second_word,
    output logic [ADDR_W-1:0] addr
);
    localparam int SHIFT = $clog2(DESC_BYTES);

    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset = ADDR_W'(idx) << SHIFT;
        if (second_word) begin
            offset = offset + ADDR_W'(WORD_BYTES);
        end
        addr = base + offset;
    end
endmodule

// File: rtl/sg_walker.sv
module sg_walker #(
    parameter int ADDR_W      = 32,
    parameter int LEN_W       = 28,
    parameter int MAX_ENTRIES = 256,
    parameter int DESC_BYTES  = 8,
    localparam int CNT_W      = $clog2(MAX_ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              sg_mode,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [LEN_W-1:0]  direct_len,
    output logic              busy,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic              seg_valid,
    input  logic              seg_ready,
    output logic [ADDR_W-1:0] seg_addr,
    output logic [LEN_W-1:0]  seg_len,
    output logic              seg_last,
    output logic              done,
    output logic [CNT_W-1:0]  done_count,
    output logic              err
);
    import sgw_pkg::*;

    localparam logic [ADDR_W-1:0] PTR_MASK  = {1'b0, {(ADDR_W-1){1'b1}}};
    localparam logic [CNT_W-1:0]  CNT_LIMIT = CNT_W'(MAX_ENTRIES);

    typedef struct packed {
        sgw_state_e        st;
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic              last;
        logic              err;
    } walk_regs_t;

    walk_regs_t r_q, r_d;

    logic [LEN_W-1:0]  dec_len;
    logic              dec_final;
    logic [ADDR_W-1:0] dec_ptr;
    logic [CNT_W-1:0]  cnt_inc;

    sgw_desc_decode #(
        .WORD_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_decode (
        .len_word  (mem_rsp_data),
        .ptr_word  (mem_rsp_data),
        .seg_len   (dec_len),
        .seg_final (dec_final),
        .seg_ptr   (dec_ptr)
    );

    sgw_addr_gen #(
        .ADDR_W     (ADDR_W),
        .IDX_W      (CNT_W),
        .DESC_BYTES (DESC_BYTES),
        .WORD_BYTES (ADDR_W / 8)
    ) u_addr (
        .base        (r_q.base),
        .idx         (r_q.cnt),
        .second_word (r_q.st == ST_REQ_PTR),
        .addr        (mem_req_addr)
    );

    assign cnt_inc = r_q.cnt + 1'b1;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.base = base_addr;
                    r_d.cnt  = '0;
                    r_d.err  = 1'b0;
                    if (sg_mode) begin
                        r_d.st = ST_REQ_LEN;
                    end else begin
                        r_d.addr = base_addr & PTR_MASK;
                        r_d.len  = direct_len;
                        r_d.last = 1'b1;
                        r_d.st   = ST_OFFER;
                    end
                end
            end
            ST_REQ_LEN: begin
                if (mem_req_ready) begin
                    r_d.st = ST_WAIT_LEN;
                end
            end
            ST_WAIT_LEN: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_err) begin
                        r_d.err = 1'b1;
                        r_d.st  = ST_FINISH;
                    end else begin
                        r_d.len  = dec_len;
                        r_d.last = dec_final;
                        r_d.st   = ST_REQ_PTR;
                    end
                end
            end
            ST_REQ_PTR: begin
                if (mem_req_ready) begin
                    r_d.st = ST_WAIT_PTR;
                end
            end
            ST_WAIT_PTR: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_err) begin
                        r_d.err = 1'b1;
                        r_d.st  = ST_FINISH;
                    end else begin
                        r_d.addr = dec_ptr;
                        r_d.st   = ST_OFFER;
                    end
                end
            end
            ST_OFFER: begin
                if (seg_ready) begin
                    r_d.cnt = cnt_inc;
                    if (r_q.last) begin
                        r_d.st = ST_FINISH;
                    end else if (cnt_inc == CNT_LIMIT) begin
                        r_d.err = 1'b1;
                        r_d.st  = ST_FINISH;
                    end else begin
                        r_d.st = ST_REQ_LEN;
                    end
                end
            end
            ST_FINISH: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy          = (r_q.st != ST_IDLE);
    assign mem_req_valid = (r_q.st == ST_REQ_LEN) || (r_q.st == ST_REQ_PTR);
    assign seg_valid     = (r_q.st == ST_OFFER);
    assign seg_addr      = r_q.addr;
    assign seg_len       = r_q.len;
    assign seg_last      = r_q.last;
    assign done          = (r_q.st == ST_FINISH);
    assign done_count    = r_q.cnt;
    assign err           = r_q.err;
endmodule

// File: rtl/sgw_checker.sv
module sgw_checker #(
    parameter int ADDR_W      = 32,
    parameter int LEN_W       = 28,
    parameter int MAX_ENTRIES = 256,
    parameter int CNT_W       = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid,
    input logic              mem_rsp_err,
    input logic              seg_valid,
    input logic              seg_ready,
    input logic [ADDR_W-1:0] seg_addr,
    input logic [LEN_W-1:0]  seg_len,
    input logic              seg_last,
    input logic              done,
    input logic [CNT_W-1:0]  done_count,
    input logic              err
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req_valid && !seg_valid && !done));

    assert_one_side_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_valid && seg_valid));

    assert_seg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_addr)
                                       && $stable(seg_len) && $stable(seg_last)));

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_final_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && seg_ready && seg_last) |=> (done && !err));

    assert_count_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_count <= CNT_W'(MAX_ENTRIES)));

    assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && mem_rsp_valid && mem_rsp_err) |=> (done && err && !mem_req_valid));

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
endmodule

bind sg_walker sgw_checker #(
    .ADDR_W      (ADDR_W),
    .LEN_W       (LEN_W),
    .MAX_ENTRIES (MAX_ENTRIES),
    .CNT_W       (CNT_W)
) u_sgw_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_err   (mem_rsp_err),
    .seg_valid     (seg_valid),
    .seg_ready     (seg_ready),
    .seg_addr      (seg_addr),
    .seg_len       (seg_len),
    .seg_last      (seg_last),
    .done          (done),
    .done_count    (done_count),
    .err           (err)
);

// File: tb/sim_sg_walker.sv
`timescale 1ns/100ps
module sim_sg_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        sg_mode = 1'b0;
    logic [31:0] base_addr = '0;
    logic [27:0] direct_len = '0;
    logic        busy;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        mem_rsp_err = 1'b0;
    logic        seg_valid;
    logic        seg_ready = 1'b0;
    logic [31:0] seg_addr;
    logic [27:0] seg_len;
    logic        seg_last;
    logic        done;
    logic [8:0]  done_count;
    logic        err;

    always #2.5 clk = ~clk;

    sg_walker u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .sg_mode(sg_mode),
        .base_addr(base_addr), .direct_len(direct_len), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
        .seg_len(seg_len), .seg_last(seg_last), .done(done),
        .done_count(done_count), .err(err)
    );

    int checks = 0;
    int errors = 0;

    logic [31:0] mem [0:1023];
    logic [31:0] exp_addr [0:511];
    logic [27:0] exp_len  [0:511];
    logic        exp_last [0:511];
    logic [31:0] got_addr [0:511];
    logic [27:0] got_len  [0:511];
    logic        got_last [0:511];

    int          nseg, nreq, wait_cnt, lat, req_pat, seg_pat, cyc;
    logic [31:0] cur_base, pend_addr, err_addr;
    logic        done_seen, err_got, prev_stall, pend;
    logic [8:0]  cnt_got;
    logic [31:0] prev_addr;
    logic [27:0] prev_len;
    logic        prev_last;

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, expv);
        end
    endtask

    function automatic logic pat_on(input int p, input int c);
        case (p)
            0: return 1'b1;
            1: return c[0];
            2: return (c % 3) == 2;
            default: return (c % 5) != 1;
        endcase
    endfunction

    // Memory responder and output monitor, all on the falling edge.
    initial begin
        nseg = 0; nreq = 0; wait_cnt = 0; cyc = 0; pend = 1'b0;
        lat = 1; req_pat = 0; seg_pat = 0; err_addr = 32'hFFFF_FFFF;
        done_seen = 1'b0; prev_stall = 1'b0; cur_base = '0;
        forever begin
            @(negedge clk);
            cyc++;
            mem_rsp_valid = 1'b0;
            mem_rsp_err   = 1'b0;
            if (pend) begin
                wait_cnt--;
                if (wait_cnt == 0) begin
                    pend          = 1'b0;
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem[pend_addr[11:2]];
                    mem_rsp_err   = (pend_addr == err_addr);
                end
            end
            mem_req_ready = pat_on(req_pat, cyc);
            seg_ready     = pat_on(seg_pat, cyc + 1);
            if (mem_req_valid && pend)
                chk(1'b0, "R2 request while read outstanding", mem_req_addr, 32'h0);
            if (mem_req_valid && mem_req_ready) begin
                // R2: length word then address word of descriptor nreq/2
                chk(mem_req_addr == cur_base + 32'((nreq / 2) * 8 + (nreq % 2) * 4),
                    "R2 request address", mem_req_addr,
                    cur_base + 32'((nreq / 2) * 8 + (nreq % 2) * 4));
                pend_addr = mem_req_addr;
                pend      = 1'b1;
                wait_cnt  = lat;
                nreq++;
            end
            if (prev_stall) begin
                chk(seg_valid && seg_addr == prev_addr && seg_len == prev_len
                    && seg_last == prev_last, "R4 segment held while stalled",
                    seg_addr, prev_addr);
            end
            prev_stall = seg_valid && !seg_ready;
            prev_addr  = seg_addr;
            prev_len   = seg_len;
            prev_last  = seg_last;
            if (seg_valid && seg_ready && nseg < 512) begin
                got_addr[nseg] = seg_addr;
                got_len[nseg]  = seg_len;
                got_last[nseg] = seg_last;
                nseg++;
            end
            if (done) begin
                done_seen = 1'b1;
                cnt_got   = done_count;
                err_got   = err;
            end
        end
    end

    task automatic build_list(input logic [31:0] base, input int n, input int last_at,
                              input int salt);
        for (int i = 0; i < n; i++) begin
            logic [31:0] lw, pw;
            lw = {(i == last_at), 3'b101, 28'(i * 32'h1357 + 32'h11 + salt)};
            pw = {i[0], 31'(i * 32'h0001_0040 + salt * 4)};
            mem[(base[11:2]) + 10'(2 * i)]     = lw;
            mem[(base[11:2]) + 10'(2 * i + 1)] = pw;
            exp_len[i]  = lw[27:0];
            exp_last[i] = lw[31];
            exp_addr[i] = {1'b0, pw[30:0]};
        end
    endtask

    task automatic run_walk(input logic sg, input logic [31:0] base, input logic [27:0] dlen,
                            input int n_exp, input int cnt_exp, input logic err_exp,
                            input int n_req_exp, input logic poke, input string tag);
        cur_base  = base;
        nseg      = 0;
        nreq      = 0;
        done_seen = 1'b0;
        @(negedge clk);
        sg_mode   = sg;
        base_addr = base;
        direct_len = dlen;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (5) @(negedge clk);
            chk(busy, "R9 walker busy before ignored start", 32'(busy), 32'h1);
            sg_mode   = 1'b0;
            base_addr = 32'h0000_0F00;
            start     = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done_seen) @(negedge clk);
        repeat (6) @(negedge clk);
        chk(nseg == n_exp, {tag, " segment count"}, 32'(nseg), 32'(n_exp));
        for (int i = 0; i < n_exp && i < nseg; i++) begin
            chk(got_addr[i] == exp_addr[i], {tag, " R3 segment address"}, got_addr[i], exp_addr[i]);
            chk(got_len[i] == exp_len[i], {tag, " R3 segment length"}, 32'(got_len[i]), 32'(exp_len[i]));
            chk(got_last[i] == exp_last[i], {tag, " R3 segment final flag"},
                32'(got_last[i]), 32'(exp_last[i]));
        end
        chk(int'(cnt_got) == cnt_exp, {tag, " R5 done count"}, 32'(cnt_got), 32'(cnt_exp));
        chk(err_got == err_exp, {tag, " error flag at done"}, 32'(err_got), 32'(err_exp));
        chk(err == err_exp, {tag, " error flag held after done"}, 32'(err), 32'(err_exp));
        chk(nreq == n_req_exp, {tag, " R2 read request count"}, 32'(nreq), 32'(n_req_exp));
        chk(!busy, {tag, " idle after done"}, 32'(busy), 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected done");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'hDEAD_0000 + 32'(i);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !mem_req_valid && !seg_valid && !done && !err, "R1 reset outputs",
            {27'h0, busy, mem_req_valid, seg_valid, done, err}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !mem_req_valid && !seg_valid && !done && !err, "R1 idle after reset",
            {27'h0, busy, mem_req_valid, seg_valid, done, err}, 32'h0);

        // R3 R4 R5: chains of length 1..6 under varied stall patterns
        for (int n = 1; n <= 6; n++) begin
            for (int p = 0; p < 4; p++) begin
                req_pat = p;
                seg_pat = (p + n) % 4;
                lat     = 1 + (n + p) % 3;
                build_list(32'h0000_0804, n, n - 1, n * 7 + p);
                run_walk(1'b1, 32'h0000_0804, '0, n, n, 1'b0, 2 * n, 1'b0, "R5 chain");
            end
        end

        // R7: direct mode, address bit 31 cleared, no reads
        req_pat = 0; seg_pat = 1; lat = 1;
        exp_addr[0] = 32'h1234_5670; exp_len[0] = 28'hABC_DEF1; exp_last[0] = 1'b1;
        run_walk(1'b0, 32'h9234_5670, 28'hABC_DEF1, 1, 1, 1'b0, 0, 1'b0, "R7 direct");

        // R9: start pulse while busy does not disturb the walk
        req_pat = 3; seg_pat = 2; lat = 2;
        build_list(32'h0000_0A00, 4, 3, 99);
        run_walk(1'b1, 32'h0000_0A00, '0, 4, 4, 1'b0, 8, 1'b1, "R9 start while busy");

        // R6: no final flag within the cap
        req_pat = 0; seg_pat = 0; lat = 1;
        build_list(32'h0000_0000, 256, 999, 3);
        run_walk(1'b1, 32'h0000_0000, '0, 256, 256, 1'b1, 512, 1'b0, "R6 cap reached");
        // R6: final flag on the last allowed entry
        build_list(32'h0000_0000, 256, 255, 5);
        run_walk(1'b1, 32'h0000_0000, '0, 256, 256, 1'b0, 512, 1'b0, "R6 final at cap");

        // R8: read error on the length word of descriptor 2
        req_pat = 1; seg_pat = 0; lat = 2;
        build_list(32'h0000_0900, 5, 4, 11);
        err_addr = 32'h0000_0910;
        run_walk(1'b1, 32'h0000_0900, '0, 2, 2, 1'b1, 5, 1'b0, "R8 error on length word");
        // R8: read error on the address word of descriptor 0
        err_addr = 32'h0000_0904;
        run_walk(1'b1, 32'h0000_0900, '0, 0, 0, 1'b1, 2, 1'b0, "R8 error on address word");
        // R8: next start clears the error flag
        err_addr = 32'hFFFF_FFFF;
        run_walk(1'b1, 32'h0000_0900, '0, 5, 5, 1'b0, 10, 1'b0, "R8 error cleared by start");

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule